// File: doc/BRIEF.md
# Bus Hold Acknowledge Controller

This block decides who owns a simple processor bus from one clock to the next. When the bus interface has work, it runs address and data phases. An external master can ask for the bus with a hold request. The controller hands the bus over only at a safe point. It then raises the hold acknowledge and turns off the output enables of every driven pin group, so those pins float.

A safe point is a bus-idle clock, or the clock in which the current cycle completes. In both cases no locked sequence may be continuing, and a narrow transfer may not still need its second half. When the hold request drops, the controller goes back to the address phase if a bus request is waiting. Otherwise it goes to idle.

The controller also watches the non-maskable interrupt line. A rising edge seen during hold is stored and shown as a pending interrupt when hold ends. A rising edge seen at any other time sets the pending flag at once. The synchronous reset input overrides everything else.

Top module: `busHoldUnit`

## Requirements
- R1: While `rst` is high, each clock edge returns the controller to idle. After that edge `holdAck` is 0, `outEn` is all ones, `addrPhase` and `dataPhase` are 0, and `nmiPending` is 0. Reset wins over a hold request that is high at the same time.
- R2: In idle with `holdReq` high and `lockActive` low, `holdAck` goes to 1 at the next clock edge. This holds even if `busReq` is also high.
- R3: While a cycle is running, hold is granted only at the edge where `cycleDone` is sampled high. `holdAck` goes to 1 at that edge. An address phase always lasts exactly one clock before the data phase. The data phase lasts until `cycleDone` is high.
- R4: If `lockActive` is high, no hold is granted, whether the bus is idle or a cycle is completing. A completing cycle then goes on to the next address phase if `busReq` is high, and to idle otherwise.
- R5: If `narrowSecond` is high when a cycle completes, the next state is always a new address phase. This wins over both a hold request and an empty request queue.
- R6: `outEn` is all zeros exactly while `holdAck` is 1, and all ones at every other time.
- R7: When `holdReq` is sampled low in hold, `holdAck` goes to 0 at that edge. The next state is the address phase (`addrPhase`=1) if `busReq` is high, and idle otherwise.
- R8: While `holdReq` stays high in hold, `busReq`, `cycleDone`, `lockActive` and `narrowSecond` have no effect. The controller stays in hold, and `addrPhase` stays 0.
- R9: Any number of `nmiIn` rising edges during hold are stored as one event. `nmiPending` goes to 1 at the edge where hold ends. `nmiTaken` high at an edge clears `nmiPending`, unless a new edge is recorded at that same edge.
- R10: A reset during hold ends the hold at the next edge and throws away a stored interrupt. `nmiPending` stays 0 after the reset.
- R11: If `holdReq` is still high when `rst` falls, the controller enters hold at the first edge after reset. No address phase runs first, even if `busReq` is high.
- R12: Outside hold, a rising edge of `nmiIn` (0 at one edge, 1 at the next) sets `nmiPending` at the edge where the 1 is sampled. A level that is already high when reset ends is not an edge.

Top module parameter: `GROUPS`, the number of output-enable groups (default 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| holdReq | input | 1 | External master asks for the bus |
| busReq | input | 1 | Internal bus request is waiting |
| cycleDone | input | 1 | Current data phase is acknowledged |
| lockActive | input | 1 | Locked sequence continues beyond this point |
| narrowSecond | input | 1 | Narrow response needs a second cycle |
| nmiIn | input | 1 | Non-maskable interrupt line, edge sensitive |
| nmiTaken | input | 1 | Pending interrupt has been serviced |
| holdAck | output | 1 | Bus granted to the external master |
| outEn | output | GROUPS | Per-group output enable, 0 = float |
| addrPhase | output | 1 | Address phase in progress |
| dataPhase | output | 1 | Data phase in progress |
| nmiPending | output | 1 | Interrupt waiting for service |

## Verification
The bench builds the block with `GROUPS` = 3, so the enable bus is small enough to compare as one word. Its width does not change the control behaviour. The ordering decisions depend on only seven single-bit inputs and four states. This small space lets the bench drive every input combination from each state and compare against a reference model it updates independently. Directed sequences then cover what a single step cannot reach: several interrupt edges during one hold, a reset during hold, and a hold request that stays high through reset.

// File: rtl/busHoldPkg.sv
package busHoldPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } busState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;
    logic enterHold;
    logic leaveHold;
  } ctrlStrobe_t;

endpackage

// File: rtl/busHoldCtrl.sv
module busHoldCtrl
  import busHoldPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        holdReq,
  input  logic        busReq,
  input  logic        cycleDone,
  input  logic        lockActive,
  input  logic        narrowSecond,
  output ctrlStrobe_t strobe,
  output logic        addrPhase,
  output logic        dataPhase
);

  busState_t state;
  busState_t nextState;
  logic      grantOk;

  assign grantOk = holdReq && !lockActive;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (grantOk)     nextState = ST_HOLD;
        else if (busReq) nextState = ST_ADDR;
      end
      ST_ADDR: nextState = ST_DATA;
      ST_DATA: begin
        if (cycleDone) begin
          if (narrowSecond) nextState = ST_ADDR;
          else if (grantOk) nextState = ST_HOLD;
          else if (busReq)  nextState = ST_ADDR;
          else              nextState = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!holdReq) nextState = busReq ? ST_ADDR : ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    strobe.clear     = rst;
    strobe.enterHold = !rst && (state != ST_HOLD) && (nextState == ST_HOLD);
    strobe.leaveHold = !rst && (state == ST_HOLD) && (nextState != ST_HOLD);
  end

  assign addrPhase = (state == ST_ADDR);
  assign dataPhase = (state == ST_DATA);

  AST_RESET_WINS: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE)); // R1

  AST_LOCK_DEFERS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && cycleDone && lockActive) |=> (state != ST_HOLD)); // R4

  AST_NARROW_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && cycleDone && narrowSecond) |=> (state == ST_ADDR)); // R5

  AST_EXIT_TARGET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !holdReq && busReq) |=> (state == ST_ADDR)); // R7

  AST_NO_ADDR_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && holdReq) |=> (state == ST_HOLD)); // R8

  AST_ADDR_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR) |=> (state == ST_DATA)); // R3

endmodule

// File: rtl/busHoldDp.sv
module busHoldDp
  import busHoldPkg::*;
#(
  parameter int GROUPS = 3
) (
  input  logic              clk,
  input  ctrlStrobe_t       strobe,
  input  logic              nmiIn,
  input  logic              nmiTaken,
  output logic              holdAck,
  output logic [GROUPS-1:0] outEn,
  output logic              nmiPending
);

  localparam logic [GROUPS-1:0] ALL_ON  = {GROUPS{1'b1}};
  localparam logic [GROUPS-1:0] ALL_OFF = {GROUPS{1'b0}};

  logic nmiPrev;
  logic nmiRise;
  logic nmiHeld;

  assign nmiRise = nmiIn && !nmiPrev;

  always_ff @(posedge clk) begin
    if (strobe.clear)          holdAck <= 1'b0;
    else if (strobe.enterHold) holdAck <= 1'b1;
    else if (strobe.leaveHold) holdAck <= 1'b0;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gEnable
    always_ff @(posedge clk) begin
      if (strobe.clear)          outEn[g] <= 1'b1;
      else if (strobe.enterHold) outEn[g] <= 1'b0;
      else if (strobe.leaveHold) outEn[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      nmiPrev    <= 1'b1;
      nmiHeld    <= 1'b0;
      nmiPending <= 1'b0;
    end else begin
      nmiPrev <= nmiIn;
      if (holdAck) begin
        if (strobe.leaveHold) begin
          nmiPending <= (nmiPending && !nmiTaken) || nmiHeld || nmiRise;
          nmiHeld    <= 1'b0;
        end else begin
          nmiPending <= nmiPending && !nmiTaken;
          nmiHeld    <= nmiHeld || nmiRise;
        end
      end else begin
        nmiPending <= (nmiPending && !nmiTaken) || nmiRise;
      end
    end
  end

  AST_FLOAT_IN_HOLD: assert property (@(posedge clk) disable iff (strobe.clear)
    holdAck |-> (outEn == ALL_OFF)); // R6

  AST_DRIVE_OUT_OF_HOLD: assert property (@(posedge clk) disable iff (strobe.clear)
    !holdAck |-> (outEn == ALL_ON)); // R6

  AST_PENDING_ON_EXIT: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.leaveHold && nmiHeld) |=> nmiPending); // R9

  AST_RESET_DROPS: assert property (@(posedge clk)
    strobe.clear |=> (!holdAck && !nmiPending)); // R10

endmodule

// File: rtl/busHoldUnit.sv
module busHoldUnit
  import busHoldPkg::*;
#(
  parameter int GROUPS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              holdReq,
  input  logic              busReq,
  input  logic              cycleDone,
  input  logic              lockActive,
  input  logic              narrowSecond,
  input  logic              nmiIn,
  input  logic              nmiTaken,
  output logic              holdAck,
  output logic [GROUPS-1:0] outEn,
  output logic              addrPhase,
  output logic              dataPhase,
  output logic              nmiPending
);

  ctrlStrobe_t strobe;

  busHoldCtrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .holdReq      (holdReq),
    .busReq       (busReq),
    .cycleDone    (cycleDone),
    .lockActive   (lockActive),
    .narrowSecond (narrowSecond),
    .strobe       (strobe),
    .addrPhase    (addrPhase),
    .dataPhase    (dataPhase)
  );

  busHoldDp #(.GROUPS(GROUPS)) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .nmiIn      (nmiIn),
    .nmiTaken   (nmiTaken),
    .holdAck    (holdAck),
    .outEn      (outEn),
    .nmiPending (nmiPending)
  );

  AST_NO_ADDR_WHILE_ACK: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> !addrPhase && !dataPhase); // R8

endmodule

// File: tb/busHoldUnit_bench.sv
`timescale 1ns/1ps
module busHoldUnit_bench;

  localparam int GROUPS = 3;

  logic clk = 1'b0;
  logic rst, holdReq, busReq, cycleDone, lockActive, narrowSecond, nmiIn, nmiTaken;
  logic holdAck, addrPhase, dataPhase, nmiPending;
  logic [GROUPS-1:0] outEn;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 address, 2 data, 3 hold
  int mSt;
  bit mAck, mPend, mHeld, mPrev;

  always #2.5 clk = ~clk;

  busHoldUnit #(.GROUPS(GROUPS)) u_busHoldUnit (
    .clk(clk), .rst(rst), .holdReq(holdReq), .busReq(busReq),
    .cycleDone(cycleDone), .lockActive(lockActive), .narrowSecond(narrowSecond),
    .nmiIn(nmiIn), .nmiTaken(nmiTaken), .holdAck(holdAck), .outEn(outEn),
    .addrPhase(addrPhase), .dataPhase(dataPhase), .nmiPending(nmiPending)
  );

  task automatic drive(input bit r, input bit h, input bit b, input bit d,
                       input bit l, input bit n, input bit m, input bit t);
    @(negedge clk);
    rst = r; holdReq = h; busReq = b; cycleDone = d;
    lockActive = l; narrowSecond = n; nmiIn = m; nmiTaken = t;
  endtask

  task automatic modelEdge();
    int nx;
    bit rise;
    if (rst) begin
      mSt = 0; mAck = 0; mPend = 0; mHeld = 0; mPrev = 1;
      return;
    end
    rise = nmiIn && !mPrev;
    mPrev = nmiIn;
    nx = mSt;
    case (mSt)
      0: if (holdReq && !lockActive) nx = 3; else if (busReq) nx = 1;
      1: nx = 2;
      2: if (cycleDone) begin
           if (narrowSecond) nx = 1;
           else if (holdReq && !lockActive) nx = 3;
           else if (busReq) nx = 1;
           else nx = 0;
         end
      default: if (!holdReq) nx = busReq ? 1 : 0;
    endcase
    if (mSt == 3) begin
      if (nx != 3) begin
        mPend = (mPend && !nmiTaken) || mHeld || rise;
        mHeld = 0;
      end else begin
        mPend = mPend && !nmiTaken;
        mHeld = mHeld || rise;
      end
    end else begin
      mPend = (mPend && !nmiTaken) || rise;
    end
    mSt = nx;
    mAck = (nx == 3);
  endtask

  task automatic step(input string tag);
    logic [GROUPS-1:0] expEn;
    @(posedge clk);
    modelEdge();
    #1;
    expEn = mAck ? '0 : '1;
    checks++;
    if (holdAck !== mAck || outEn !== expEn || addrPhase !== (mSt == 1) ||
        dataPhase !== (mSt == 2) || nmiPending !== mPend) begin
      fails++;
      $display("FAIL %s: ack/en/addr/data/nmi actual %b/%b/%b/%b/%b expected %b/%b/%b/%b/%b",
               tag, holdAck, outEn, addrPhase, dataPhase, nmiPending,
               mAck, expEn, (mSt == 1), (mSt == 2), mPend);
    end
  endtask

  task automatic resetFor(input bit h, input bit b);
    drive(1, h, b, 0, 0, 0, 0, 0);
    step("R1");
    step("R1");
  endtask

  initial begin
    rst = 1; holdReq = 0; busReq = 0; cycleDone = 0;
    lockActive = 0; narrowSecond = 0; nmiIn = 0; nmiTaken = 0;
    mSt = 0; mAck = 0; mPend = 0; mHeld = 0; mPrev = 1;

    // R1: reset state, reset beats a simultaneous hold request
    resetFor(1, 1);

    // Single-step sweep: every input combination from every state
    for (int st = 0; st < 4; st++) begin
      for (int c = 0; c < 128; c++) begin
        string tag;
        resetFor(0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        step("R1");
        if (st == 1 || st == 2) begin
          drive(0, 0, 1, 0, 0, 0, 0, 0); step("R3");
        end
        if (st == 2) begin
          drive(0, 0, 0, 0, 0, 0, 0, 0); step("R3");
        end
        if (st == 3) begin
          drive(0, 1, 0, 0, 0, 0, 0, 0); step("R2");
        end
        case (st)
          0: tag = c[3] ? "R4" : (c[0] ? "R2" : "R12");
          1: tag = "R3";
          2: tag = c[4] ? "R5" : (c[3] ? "R4" : "R3");
          default: tag = c[0] ? "R8" : "R7";
        endcase
        drive(0, c[0], c[1], c[2], c[3], c[4], c[5], c[6]);
        step(tag);
        drive(0, c[0], c[1], 0, 0, 0, c[5], 0);
        step(tag);
      end
    end

    // R11: hold request held through reset with a waiting bus request
    resetFor(1, 1);
    drive(0, 1, 1, 0, 0, 0, 0, 0); step("R11");
    step("R11");

    // R9: several NMI edges during hold, presented once on exit, then serviced
    resetFor(0, 0);
    drive(0, 1, 0, 0, 0, 0, 0, 0); step("R2");
    for (int k = 0; k < 3; k++) begin
      drive(0, 1, 0, 0, 0, 0, 1, 0); step("R9");
      drive(0, 1, 0, 0, 0, 0, 0, 0); step("R9");
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0); step("R9");
    drive(0, 0, 0, 0, 0, 0, 0, 0); step("R9");
    drive(0, 0, 0, 0, 0, 0, 0, 1); step("R9");
    drive(0, 0, 0, 0, 0, 0, 0, 0); step("R9");

    // R10: reset during hold discards the captured edge
    drive(0, 1, 0, 0, 0, 0, 0, 0); step("R2");
    drive(0, 1, 0, 0, 0, 0, 1, 0); step("R10");
    drive(1, 1, 0, 0, 0, 0, 1, 0); step("R10");
    drive(0, 0, 0, 0, 0, 0, 1, 0); step("R10");
    step("R10");

    // R12: NMI level high through reset is not an edge; a later edge is
    drive(0, 0, 0, 0, 0, 0, 0, 0); step("R12");
    drive(0, 0, 1, 0, 0, 0, 1, 0); step("R12");
    step("R12");

    // R4 and R6: locked back-to-back cycles with a waiting hold request
    resetFor(0, 0);
    drive(0, 1, 1, 0, 1, 0, 0, 0); step("R4");
    step("R4");
    drive(0, 1, 1, 1, 1, 0, 0, 0); step("R4");
    drive(0, 1, 0, 0, 0, 0, 0, 0); step("R4");
    drive(0, 1, 0, 1, 0, 0, 0, 0); step("R6");
    step("R6");
    drive(0, 0, 1, 0, 0, 0, 0, 0); step("R7");
    step("R7");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule